// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in, first-out store built from a parameterised array of register words. A stack pointer always addresses the current top item. The pointer wraps modulo the depth, so both the full condition and the empty condition are detected when the pointer lands on zero. Two flag registers, `full` and `empty`, record which of the two it is.

A push first advances the pointer and then writes the incoming word at the new position. The first item therefore goes to word 1, and the item that fills the stack goes to word 0. A pop copies the top word into a registered output and then moves the pointer back. A request that the current state cannot serve is rejected. Such requests are a push while full, a pop while empty, or a push and a pop in the same cycle. A rejected request leaves the pointer, the storage and the flags as they were. It raises a one-cycle error pulse with a cause code.

Data enters on a valid/ready channel. `in_ready` equals `!full`, and a word transfers on a clock edge where `in_valid` and `in_ready` are both high and `pop_req` is low. Holding `in_valid` high while `in_ready` is low is treated as an overflow attempt, and that word is not stored. Popped data leaves on `out_valid`/`out_data`, which has no ready. The consumer must take `out_data` in the cycle where `out_valid` is high. `out_data` keeps the last popped word until the next pop.

Top module: `reg_stack`

## Requirements
- R1: After reset `empty` = 1, `full` = 0, `in_ready` = 1, `err` = 0, `err_cause` = 2'b00 and `out_valid` = 0.
- R2: A push accepted at an edge stores `in_data` and clears `empty` after that edge.
- R3: A pop accepted at an edge drives `out_valid` = 1 for the following cycle, with `out_data` equal to the most recently pushed word not yet popped.
- R4: `full` rises after the DEPTH-th accepted push counted from empty with no pop in between, and not after any earlier one. `in_ready` is always `!full`.
- R5: `empty` rises after the pop that removes the last stored word. Any accepted pop clears `full`. `full` and `empty` are never both high.
- R6: A push request while `full` = 1 is rejected: `err` pulses with `err_cause` = 2'b01, and `full`, the pointer and the stored words are unchanged.
- R7: A pop request while `empty` = 1 is rejected: `err` pulses with `err_cause` = 2'b10, `out_valid` stays 0 and `empty` stays 1.
- R8: A push and a pop requested in the same cycle are both rejected: `err` pulses with `err_cause` = 2'b11 and nothing is stored or removed.
- R9: `err` is high for exactly the one cycle after each rejected request, and `err_cause` is 2'b00 whenever `err` is low.
- R10: After the stack has been filled and fully drained, the wrapped pointer lets it be filled and drained again with correct order and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Push request with data |
| in_ready | output | 1 | Stack can accept a push (not full) |
| in_data | input | DW | Word to push |
| pop_req | input | 1 | Pop request |
| out_valid | output | 1 | One-cycle strobe: `out_data` holds a popped word |
| out_data | output | DW | Last popped word |
| full | output | 1 | All DEPTH words occupied |
| empty | output | 1 | No words stored |
| err | output | 1 | One-cycle pulse after a rejected request |
| err_cause | output | 2 | 01 overflow, 10 underflow, 11 push and pop together, 00 none |

## Verification
The hardest state to reach is the wrap point. There, the DEPTH-th push sends the pointer back to zero and writes word 0, and the first pop after that must read word 0 and step the pointer back to DEPTH-1. The bench reaches it by pushing exactly DEPTH distinct words. It then attempts an overflow at that point, drains the stack while checking every word in reverse order, and fills it a second time, which exercises the wrap in both directions twice.

// File: rtl/reg_stack_pkg.sv
package reg_stack_pkg;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'b00,
    ERR_OVERFLOW  = 2'b01,
    ERR_UNDERFLOW = 2'b10,
    ERR_COLLIDE   = 2'b11
  } stk_err_e;

endpackage

// File: rtl/reg_stack_ctrl.sv
module reg_stack_ctrl
  import reg_stack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_in,
  input  logic       pop_in,
  input  logic       full,
  input  logic       empty,
  output logic       push_ok,
  output logic       pop_ok,
  output logic       err,
  output stk_err_e   err_cause
);

  stk_err_e cause_d;

  // legality decode: exactly one of push, pop or a fault per cycle
  always_comb begin
    push_ok = 1'b0;
    pop_ok  = 1'b0;
    cause_d = ERR_NONE;
    if (push_in && pop_in) begin
      cause_d = ERR_COLLIDE;
    end else if (push_in) begin
      if (full) cause_d = ERR_OVERFLOW;
      else      push_ok = 1'b1;
    end else if (pop_in) begin
      if (empty) cause_d = ERR_UNDERFLOW;
      else       pop_ok = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err       <= 1'b0;
      err_cause <= ERR_NONE;
    end else begin
      err       <= (cause_d != ERR_NONE);
      err_cause <= cause_d;
    end
  end

  // R9: cause is zero whenever no error is flagged
  assert_cause_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> (err_cause == ERR_NONE));

  // R8: collision always yields the collision cause next cycle
  assert_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_in && pop_in) |=> (err && err_cause == ERR_COLLIDE));

  // R6: push on a full stack reported as overflow
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_in && !pop_in && full) |=> (err && err_cause == ERR_OVERFLOW));

  // R7: pop on an empty stack reported as underflow
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_in && !push_in && empty) |=> (err && err_cause == ERR_UNDERFLOW));

endmodule

// File: rtl/reg_stack_ptr.sv
module reg_stack_ptr #(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          pop_ok,
  output logic [PW-1:0] sp,
  output logic [PW-1:0] sp_inc,
  output logic          full,
  output logic          empty
);

  localparam logic [PW-1:0] TOP_IDX = PW'(DEPTH - 1);

  logic [PW-1:0] sp_dec;

  // explicit wrap so a non power of two depth also works
  assign sp_inc = (sp == TOP_IDX) ? '0 : sp + 1'b1;
  assign sp_dec = (sp == '0) ? TOP_IDX : sp - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else if (push_ok) begin
      sp    <= sp_inc;
      empty <= 1'b0;
      full  <= (sp_inc == '0);
    end else if (pop_ok) begin
      sp    <= sp_dec;
      full  <= 1'b0;
      empty <= (sp_dec == '0);
    end
  end

  // R5: the two flags are exclusive
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R4: full can only hold with the pointer at the wrap point
  assert_full_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (sp == '0));

  // R5: empty can only hold with the pointer at the wrap point
  assert_empty_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (sp == '0));

  // R6/R7/R8: an idle or rejected cycle leaves the pointer alone
  assert_sp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ok && !pop_ok) |=> $stable(sp));

endmodule

// File: rtl/reg_stack_mem.sv
module reg_stack_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0]    words [DEPTH];
  logic [DEPTH-1:0] we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign we[g] = wr_en && (wr_addr == AW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we[i]) words[i] <= wr_data;
    end
  end

  assign rd_data = words[rd_addr];

  // R2: at most one word written per edge
  assert_single_write_R2: assert property (@(posedge clk)
    $onehot0(we));

endmodule

// File: rtl/reg_stack.sv
module reg_stack
  import reg_stack_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          pop_req,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          full,
  output logic          empty,
  output logic          err,
  output logic [1:0]    err_cause
);

  logic          push_ok;
  logic          pop_ok;
  logic [PW-1:0] sp;
  logic [PW-1:0] sp_inc;
  logic [DW-1:0] rd_data;
  stk_err_e      cause_q;

  reg_stack_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_in   (in_valid),
    .pop_in    (pop_req),
    .full      (full),
    .empty     (empty),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .err       (err),
    .err_cause (cause_q)
  );

  reg_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .sp      (sp),
    .sp_inc  (sp_inc),
    .full    (full),
    .empty   (empty)
  );

  // write lands at the advanced pointer, read comes from the current one
  reg_stack_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk     (clk),
    .wr_en   (push_ok),
    .wr_addr (sp_inc),
    .wr_data (in_data),
    .rd_addr (sp),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pop_ok;
      if (pop_ok) out_data <= rd_data;
    end
  end

  assign in_ready  = !full;
  assign err_cause = cause_q;

  // R3: a popped word appears only after a pop request
  assert_out_after_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pop_req));

  // R7: a rejected pop produces no output strobe
  assert_no_strobe_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> !out_valid);

  // R4: back-pressure follows the full flag
  assert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !full);

endmodule

// File: tb/reg_stack_tb_top.sv
module reg_stack_tb_top;

  localparam int DEPTH = 64;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          pop_req = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          full;
  logic          empty;
  logic          err;
  logic [1:0]    err_cause;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  reg_stack #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .pop_req   (pop_req),
    .out_valid (out_valid),
    .out_data  (out_data),
    .full      (full),
    .empty     (empty),
    .err       (err),
    .err_cause (err_cause)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int seed);
    return DW'(i * 5 + seed);
  endfunction

  // each op: drive after a falling edge, sample at the next falling edge
  task automatic push_word(input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_word();
    @(negedge clk);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "err", int'(err), 0);
    chk("R1", "err_cause", int'(err_cause), 0);
    chk("R1", "out_valid", int'(out_valid), 0);
  endtask

  task automatic t_lifo();
    push_word(8'h11);
    chk("R2", "empty after push", int'(empty), 0);
    push_word(8'h22);
    push_word(8'h33);
    pop_word();
    chk("R3", "out_valid", int'(out_valid), 1);
    chk("R3", "data 1st pop", int'(out_data), 8'h33);
    @(negedge clk);
    chk("R3", "out_valid drops", int'(out_valid), 0);
    chk("R3", "data held", int'(out_data), 8'h33);
    push_word(8'h44);
    pop_word();
    chk("R3", "data after repush", int'(out_data), 8'h44);
    pop_word();
    chk("R3", "data 3rd pop", int'(out_data), 8'h22);
    pop_word();
    chk("R3", "data last pop", int'(out_data), 8'h11);
    chk("R5", "empty after last pop", int'(empty), 1);
  endtask

  task automatic t_fill_drain(input int seed);
    for (int i = 0; i < DEPTH - 1; i++) push_word(pat(i, seed));
    chk("R4", "full before last", int'(full), 0);
    chk("R4", "ready before last", int'(in_ready), 1);
    push_word(pat(DEPTH - 1, seed));
    chk("R4", "full at depth", int'(full), 1);
    chk("R4", "ready at depth", int'(in_ready), 0);
    chk("R5", "empty at depth", int'(empty), 0);
    // R6: overflow attempt
    push_word(8'hEE);
    chk("R6", "err", int'(err), 1);
    chk("R6", "cause", int'(err_cause), 1);
    chk("R6", "full kept", int'(full), 1);
    @(negedge clk);
    chk("R9", "err one cycle", int'(err), 0);
    chk("R9", "cause cleared", int'(err_cause), 0);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      pop_word();
      chk("R3", "drain strobe", int'(out_valid), 1);
      chk("R10", "drain data", int'(out_data), int'(pat(i, seed)));
      if (i == DEPTH - 1) chk("R5", "full cleared by pop", int'(full), 0);
      if (i > 0) chk("R5", "not empty mid drain", int'(empty), 0);
    end
    chk("R5", "empty after drain", int'(empty), 1);
  endtask

  task automatic t_underflow();
    pop_word();
    chk("R7", "err", int'(err), 1);
    chk("R7", "cause", int'(err_cause), 2);
    chk("R7", "no strobe", int'(out_valid), 0);
    chk("R7", "empty kept", int'(empty), 1);
    @(negedge clk);
    chk("R9", "err one cycle", int'(err), 0);
    push_word(8'h5A);
    pop_word();
    chk("R7", "state intact data", int'(out_data), 8'h5A);
    chk("R7", "state intact empty", int'(empty), 1);
  endtask

  task automatic t_collide();
    push_word(8'hA1);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hB2;
    pop_req  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    pop_req  = 1'b0;
    chk("R8", "err", int'(err), 1);
    chk("R8", "cause", int'(err_cause), 3);
    chk("R8", "no strobe", int'(out_valid), 0);
    chk("R8", "empty", int'(empty), 0);
    @(negedge clk);
    chk("R9", "err one cycle", int'(err), 0);
    pop_word();
    chk("R8", "top unchanged", int'(out_data), 8'hA1);
    chk("R8", "nothing added", int'(empty), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lifo();
    t_fill_drain(3);
    t_underflow();
    t_collide();
    t_fill_drain(77);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule